// File: doc/BRIEF.md
# GPIO Interrupt and Wake Event Detector

This block watches a word of already-synchronized GPIO input levels and turns them into interrupt and wake events. Software configures each pin through a simple register bus. A pin can be edge-triggered, firing on a rising edge, a falling edge or both. It can instead be level-triggered, firing while its input sits at a programmed active level.

Detected events land in a sticky interrupt status word. Software acknowledges a bit by writing a one to it. A registered combined interrupt line rises whenever any status bit is set that software has also unmasked.

A separate wake mask decides which pins may also record into a wake status word. The wake request output is the OR of that word. Wake status is acknowledged the same way, by writing ones.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset every configuration, mask and status register reads 0, and `irq_o` and `wake_o` are 0. With everything cleared, pin activity sets no status bit.
- R2: When bit n of the rising-enable register (offset 0x064) is 1 and pin n is in edge mode, a 0-to-1 change of `pin_lvl_i[n]` sets interrupt status bit n. Edges are found by comparing the level with its value one clock earlier.
- R3: When bit n of the falling-enable register (offset 0x07C) is 1 and pin n is in edge mode, a 1-to-0 change sets status bit n. With both enables set, the pin captures both edges.
- R4: Bit n of the type register (offset 0x300) set to 1 selects level mode for pin n; 0 selects edge mode. In level mode, bit n of the polarity register (offset 0x318) selects low-active when 1 and high-active when 0. The status bit is set again on every clock while the active level persists.
- R5: The interrupt status register (offset 0x0C4) is cleared bit by bit by writing 1; writing 0 leaves a bit unchanged. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R6: The interrupt mask (offset 0x0AC) gates only the output, and a bit value of 1 enables the pin. Status is recorded whatever the mask holds. `irq_o` is registered: it reflects the OR of status AND mask one clock after that value appears.
- R7: Wake status (offset 0x418) records an event on pin n only if bit n of the wake mask (offset 0x400) is 1. It is cleared by writing 1, with a new event winning over a clear. `wake_o` is the OR of the wake status bits.
- R8: Every register reads back its stored value at its own offset, and any other offset reads 0. Pin n uses bit n of each word.
- R9: A pin in edge mode with neither edge enable set records no event on either edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NPIN | Synchronized pin levels |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | AW | Byte offset of the register accessed |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined registered interrupt |
| wake_o | output | 1 | Wake request |

## Verification
Some properties are checked on every cycle by assertions:
- A write-one clear of a status bit takes effect in the next cycle.
- A new event always survives a same-cycle clear.
- A wake status bit can only rise where the wake mask was set.
- The interrupt line follows the masked status with one cycle of lag.

Other behaviours only the bench scenarios can show:
- The decode of each register offset.
- The polarity choice in level mode.
- Level status coming back after an acknowledge while the level is held.
- Both-edge capture.
- The quiet state after a reset applied in the middle of a run.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned ADDR_W = 12;

  // register identifiers for the configuration bank
  localparam int unsigned CFG_RISE = 0;
  localparam int unsigned CFG_FALL = 1;
  localparam int unsigned CFG_LVL  = 2;
  localparam int unsigned CFG_POL  = 3;
  localparam int unsigned CFG_IMSK = 4;
  localparam int unsigned CFG_WMSK = 5;
  localparam int unsigned NCFG     = 6;

  localparam logic [ADDR_W-1:0] OFF_ISTAT = 12'h0C4;
  localparam logic [ADDR_W-1:0] OFF_WSTAT = 12'h418;

  function automatic logic [ADDR_W-1:0] cfg_offset(input int unsigned idx);
    case (idx)
      CFG_RISE: cfg_offset = 12'h064;
      CFG_FALL: cfg_offset = 12'h07C;
      CFG_LVL:  cfg_offset = 12'h300;
      CFG_POL:  cfg_offset = 12'h318;
      CFG_IMSK: cfg_offset = 12'h0AC;
      default:  cfg_offset = 12'h400;
    endcase
  endfunction
endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NPIN-1:0]   istat_i,
  input  logic [NPIN-1:0]   wstat_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NPIN-1:0]   rise_en_o,
  output logic [NPIN-1:0]   fall_en_o,
  output logic [NPIN-1:0]   lvl_sel_o,
  output logic [NPIN-1:0]   pol_low_o,
  output logic [NPIN-1:0]   imask_o,
  output logic [NPIN-1:0]   wmask_o,
  output logic [NPIN-1:0]   iclr_o,
  output logic [NPIN-1:0]   wclr_o
);
  localparam int unsigned PAD = DW - NPIN;

  logic [NPIN-1:0] cfg_q [NCFG];
  logic [NPIN-1:0] cfg_d [NCFG];
  logic [NCFG-1:0] cfg_en;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_comb begin
      cfg_en[g] = wr_i && (addr_i == cfg_offset(g));
      cfg_d[g]  = cfg_en[g] ? wdata_i[NPIN-1:0] : cfg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (cfg_en[g]) begin
        cfg_q[g] <= cfg_d[g];
      end
    end
  end

  always_comb begin
    rise_en_o = cfg_q[CFG_RISE];
    fall_en_o = cfg_q[CFG_FALL];
    lvl_sel_o = cfg_q[CFG_LVL];
    pol_low_o = cfg_q[CFG_POL];
    imask_o   = cfg_q[CFG_IMSK];
    wmask_o   = cfg_q[CFG_WMSK];
    iclr_o    = (wr_i && addr_i == OFF_ISTAT) ? wdata_i[NPIN-1:0] : '0;
    wclr_o    = (wr_i && addr_i == OFF_WSTAT) ? wdata_i[NPIN-1:0] : '0;
  end

  logic [NPIN-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCFG; i++) begin
      if (addr_i == cfg_offset(i)) rd_word = cfg_q[i];
    end
    if (addr_i == OFF_ISTAT) rd_word = istat_i;
    if (addr_i == OFF_WSTAT) rd_word = wstat_i;
  end

  if (PAD > 0) begin : g_pad
    assign rdata_o = {{PAD{1'b0}}, rd_word};
  end else begin : g_nopad
    assign rdata_o = rd_word;
  end

  // R8: a write to a configuration offset is visible on the next cycle
  a_r8_cfg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == cfg_offset(CFG_IMSK)) |=> (imask_o == $past(wdata_i[NPIN-1:0])));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] rise_en_i,
  input  logic [NPIN-1:0] fall_en_i,
  input  logic [NPIN-1:0] lvl_sel_i,
  input  logic [NPIN-1:0] pol_low_i,
  output logic [NPIN-1:0] evt_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise_hit, fall_hit, lvl_hit;
    always_comb begin
      rise_hit = rise_en_i[p] &&  lvl_i[p] && !prev_q[p];
      fall_hit = fall_en_i[p] && !lvl_i[p] &&  prev_q[p];
      lvl_hit  = lvl_i[p] ^ pol_low_i[p];
      evt_o[p] = lvl_sel_i[p] ? lvl_hit : (rise_hit || fall_hit);
    end
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] stat_o
);
  logic [NPIN-1:0] stat_q, stat_d;
  logic            upd;

  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_i;
    upd    = (|set_i) || (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd) begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R5: an unopposed write-one clear empties the bit on the next cycle
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  // R5: a new event is held even when a clear arrives in the same cycle
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPIN = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_o,
  output logic            wake_o
);
  logic [NPIN-1:0] rise_en, fall_en, lvl_sel, pol_low, imask, wmask;
  logic [NPIN-1:0] iclr, wclr, istat, wstat, evt, wevt;
  logic            irq_d, irq_q;

  gpio_evt_cfg #(.NPIN(NPIN), .DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .istat_i   (istat),
    .wstat_i   (wstat),
    .rdata_o   (bus_rdata_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .lvl_sel_o (lvl_sel),
    .pol_low_o (pol_low),
    .imask_o   (imask),
    .wmask_o   (wmask),
    .iclr_o    (iclr),
    .wclr_o    (wclr)
  );

  gpio_evt_detect #(.NPIN(NPIN)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (pin_lvl_i),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .lvl_sel_i (lvl_sel),
    .pol_low_i (pol_low),
    .evt_o     (evt)
  );

  assign wevt = evt & wmask;

  gpio_evt_status #(.NPIN(NPIN)) u_istat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt),
    .clr_i  (iclr),
    .stat_o (istat)
  );

  gpio_evt_status #(.NPIN(NPIN)) u_wstat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wevt),
    .clr_i  (wclr),
    .stat_o (wstat)
  );

  always_comb begin
    irq_d = |(istat & imask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = |wstat;

  // R7: wake status only gains bits on pins whose wake mask was set
  a_r7_wake_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wstat & ~$past(wstat) & ~$past(wmask)) == '0));

  // R6: an all-zero mask keeps the interrupt line low on the next cycle
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '0) |=> !irq_o);

  // R6: an unmasked pending bit raises the line one cycle later
  a_r6_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(istat & imask)) |=> irq_o);
endmodule

// File: tb/gpio_evt_top_tb.sv
module gpio_evt_top_tb;
  localparam int CLK_P = 10;
  localparam int NPIN  = 32;
  localparam int NVEC  = 26;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] pins;
    logic        wr;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] rexp;
    logic        irq;
    logic        wake;
  } vec_t;

  // offsets: rise 064, fall 07C, mask 0AC, status 0C4, type 300, pol 318, wmask 400, wstat 418
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 32'h0, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R1 idle
    '{4'd8, 32'h0, 1'b1, 12'h064, 32'h1, 12'h064, 32'h1, 1'b0, 1'b0}, // R8 rise enable readback
    '{4'd6, 32'h1, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h1, 1'b0, 1'b0}, // R2 R6 captured while masked
    '{4'd6, 32'h1, 1'b1, 12'h0AC, 32'h1, 12'h0C4, 32'h1, 1'b1, 1'b0}, // R6 unmask raises irq
    '{4'd5, 32'h1, 1'b1, 12'h0C4, 32'h0, 12'h0C4, 32'h1, 1'b1, 1'b0}, // R5 write 0 no effect
    '{4'd5, 32'h1, 1'b1, 12'h0C4, 32'h1, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R5 ack clears
    '{4'd9, 32'h0, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R9 fall not enabled
    '{4'd8, 32'h0, 1'b1, 12'h07C, 32'h1, 12'h07C, 32'h1, 1'b0, 1'b0}, // R8 fall enable readback
    '{4'd3, 32'h1, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h1, 1'b1, 1'b0}, // R3 both enabled, rise
    '{4'd5, 32'h0, 1'b1, 12'h0C4, 32'h1, 12'h0C4, 32'h1, 1'b1, 1'b0}, // R3 R5 fall beats clear
    '{4'd5, 32'h0, 1'b1, 12'h0C4, 32'h1, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R5 ack
    '{4'd4, 32'h0, 1'b1, 12'h318, 32'h2, 12'h318, 32'h2, 1'b0, 1'b0}, // R4 polarity low, still edge
    '{4'd4, 32'h0, 1'b1, 12'h300, 32'h2, 12'h0C4, 32'h2, 1'b0, 1'b0}, // R4 level low active
    '{4'd6, 32'h0, 1'b1, 12'h0AC, 32'h3, 12'h0AC, 32'h3, 1'b1, 1'b0}, // R6 unmask pin 1
    '{4'd4, 32'h0, 1'b1, 12'h0C4, 32'h2, 12'h0C4, 32'h2, 1'b1, 1'b0}, // R4 ack ineffective
    '{4'd4, 32'h2, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h2, 1'b1, 1'b0}, // R4 level gone, sticky
    '{4'd4, 32'h2, 1'b1, 12'h0C4, 32'h2, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R4 ack now holds
    '{4'd7, 32'h2, 1'b1, 12'h400, 32'h1, 12'h400, 32'h1, 1'b0, 1'b0}, // R7 wake mask
    '{4'd7, 32'h3, 1'b0, 12'h000, 32'h0, 12'h418, 32'h1, 1'b1, 1'b1}, // R7 wake recorded
    '{4'd7, 32'h3, 1'b1, 12'h418, 32'h1, 12'h418, 32'h0, 1'b1, 1'b0}, // R7 wake ack
    '{4'd5, 32'h3, 1'b1, 12'h0C4, 32'h1, 12'h0C4, 32'h0, 1'b0, 1'b0}, // R5 ack
    '{4'd2, 32'h3, 1'b1, 12'h064, 32'h5, 12'h064, 32'h5, 1'b0, 1'b0}, // R2 enable pin 2
    '{4'd7, 32'h7, 1'b0, 12'h000, 32'h0, 12'h418, 32'h0, 1'b0, 1'b0}, // R7 unmasked pin no wake
    '{4'd2, 32'h7, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h4, 1'b0, 1'b0}, // R2 pin 2 status
    '{4'd8, 32'h7, 1'b0, 12'h000, 32'h0, 12'h010, 32'h0, 1'b0, 1'b0}, // R8 unmapped reads 0
    '{4'd3, 32'h6, 1'b0, 12'h000, 32'h0, 12'h0C4, 32'h5, 1'b1, 1'b1}  // R3 fall on pin 0
  };

  logic        clk, rst_n, bus_wr, irq, wake;
  logic [31:0] pins, wdata, rdata;
  logic [11:0] addr;
  int errors = 0;
  int checks = 0;
  bit done   = 0;

  gpio_evt_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl_i   (pins),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    pins = 32'h5;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pins = 32'h0;
    @(negedge clk);
    // R1: reset state and no event from pin activity
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 wake after reset", {31'b0, wake}, 32'h0);
    rd_chk("R1 status after reset", 12'h0C4, 32'h0);
    rd_chk("R1 type after reset", 12'h300, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      pins = VECS[v].pins; bus_wr = VECS[v].wr; addr = VECS[v].waddr; wdata = VECS[v].wdata;
      @(negedge clk);
      bus_wr = 1'b0; addr = VECS[v].raddr;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d rdata", VECS[v].req, v), rdata, VECS[v].rexp);
      chk($sformatf("R%0d vec %0d irq", VECS[v].req, v), {31'b0, irq}, {31'b0, VECS[v].irq});
      chk($sformatf("R%0d vec %0d wake", VECS[v].req, v), {31'b0, wake}, {31'b0, VECS[v].wake});
    end

    // R1: reset mid-run with irq and wake both active
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 irq during reset", {31'b0, irq}, 32'h0);
    chk("R1 wake during reset", {31'b0, wake}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    pins = 32'h1;
    @(negedge clk);
    pins = 32'h0;
    @(negedge clk);
    @(negedge clk);
    rd_chk("R1 rise cleared", 12'h064, 32'h0);
    rd_chk("R1 mask cleared", 12'h0AC, 32'h0);
    rd_chk("R1 wmask cleared", 12'h400, 32'h0);
    rd_chk("R1 status stays 0", 12'h0C4, 32'h0);
    rd_chk("R1 wake status stays 0", 12'h418, 32'h0);
    chk("R1 irq quiet", {31'b0, irq}, 32'h0);

    // R4: high-active level on pin 3, reasserts after ack while held high
    @(negedge clk);
    bus_wr = 1'b1; addr = 12'h300; wdata = 32'h8;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk("R4 pin low no status", 12'h0C4, 32'h0);
    pins = 32'h8;
    @(negedge clk);
    rd_chk("R4 high level sets", 12'h0C4, 32'h8);
    bus_wr = 1'b1; addr = 12'h0C4; wdata = 32'h8;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk("R4 status back after ack", 12'h0C4, 32'h8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule